// File: doc/BRIEF.md
# Phase-Mode Frequency and Phase Programming Sequencer

This block turns one programming command for a synthesizer channel into a fixed series of register writes on a generic write port. A command names a channel and gives a 32-bit frequency word, a 16-bit phase word, a phase mode and two timestamps: a reference time and the current time. The block selects the channel, loads the frequency in two halves, sets whether the phase accumulator is cleared on the next update, loads the corrected phase word and finally strobes an update.

Three phase modes are supported. In continuous mode the accumulator is never cleared, and a per-channel stored correction is added so the output stays coherent with the last absolute or tracking setting. In absolute mode the accumulator is cleared at the update, and the phase word is pulled back by the phase that the new frequency would gather between the update instant and the reference time. Tracking mode also adds the phase gathered from time zero to the reference time. Absolute and tracking results are kept as the channel's correction for later continuous commands. Commands are taken over a valid/ready handshake. Each write takes a slot of a fixed number of cycles.

Top module: `dds_phase_sequencer`

## Requirements
- R1: After reset, cmd_ready is 1, wr_stb is 0, wr_addr is 0 and every channel's stored correction is 0.
- R2: A command is accepted on a clock edge where cmd_valid and cmd_ready are both 1. For a valid channel, cmd_ready is 0 from the next cycle until the last write slot ends. Six writes follow, each with a one-cycle wr_stb at the start of a SLOT_CYCLES-cycle slot (5 by default), and the first strobe comes in the cycle after acceptance. wr_addr and wr_data hold for the whole slot.
- R3: The first write goes to address 0x81, with data equal to the channel number shifted left by one bit.
- R4: The second write goes to 0x2D with frequency bits 15:0. The third goes to 0x2F with frequency bits 31:16.
- R5: The fourth write goes to 0x01. Its data is 0x0008 for mode code 0 (continuous) and 0x2008 for codes 1, 2 and 3, which clear the accumulator on update.
- R6: For mode code 1 (absolute), and also code 3, the phase written is pow − bits[31:16] of ((ref − (now + 2·SLOT_CYCLES)) · CLK_RATIO · ftw). All arithmetic is modulo 2^64, and the result is kept to 16 bits.
- R7: For mode code 2 (tracking), the phase written is the R6 value plus bits[31:16] of (ref · CLK_RATIO · ftw), modulo 2^16.
- R8: An absolute or tracking command stores its written phase as that channel's correction. A continuous command writes pow plus the stored correction of its own channel, modulo 2^16, and leaves every stored value unchanged.
- R9: The fifth write goes to 0x31 with the phase word. The sixth goes to 0x80 with data 0. cmd_ready returns to 1 in the cycle after the last slot ends.
- R10: A command whose channel is NUM_CH or more is accepted but produces no write. cmd_ready stays 1, and no stored correction changes, including the correction of the channel that the low bits of the rejected number would alias.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Sequencer idle and able to take a command |
| cmd_chan | input | 8 | Channel number |
| cmd_ftw | input | 32 | Frequency tuning word |
| cmd_pow | input | 16 | Phase offset word |
| cmd_mode | input | 2 | Phase mode: 0 continuous, 1 absolute, 2 tracking, 3 absolute |
| cmd_ref | input | 64 | Reference timestamp |
| cmd_now | input | 64 | Current timestamp |
| wr_addr | output | 8 | Register write address |
| wr_data | output | 16 | Register write data |
| wr_stb | output | 1 | One-cycle strobe at the start of each write slot |

## Verification
The hardest situation to reach from the ports is a continuous command that depends on a correction stored earlier by a different command. A wrong channel index or a missed store only shows up later, on another channel or another command. The stimulus table therefore chains commands: an absolute or tracking command on a channel, then a continuous one on the same channel, with differences between reference and current time both forward and wrapped negative. Directed cases then send out-of-range channel numbers that alias channel 0 and follow them with a continuous command on channel 0, so that any corruption of the stored value appears on the phase write.

// File: rtl/dds_seq_pkg.sv
// Shared constants and types for the phase-mode programming sequencer.
// Assumes a 16-bit register data path and 8-bit register addresses.
package dds_seq_pkg;
    typedef enum logic [1:0] {
        MODE_CONT    = 2'd0,
        MODE_ABS     = 2'd1,
        MODE_TRACK   = 2'd2,
        MODE_ABS_ALT = 2'd3
    } phase_mode_e;

    localparam logic [7:0] ADDR_SEL     = 8'h81;
    localparam logic [7:0] ADDR_FREQ_LO = 8'h2D;
    localparam logic [7:0] ADDR_FREQ_HI = 8'h2F;
    localparam logic [7:0] ADDR_CFG     = 8'h01;
    localparam logic [7:0] ADDR_PHASE   = 8'h31;
    localparam logic [7:0] ADDR_UPDATE  = 8'h80;

    localparam logic [15:0] CFG_KEEP  = 16'h0008;
    localparam logic [15:0] CFG_CLEAR = 16'h2008;

    localparam int NUM_STEPS  = 6;
    localparam int STEP_SEL   = 0;
    localparam int STEP_FLO   = 1;
    localparam int STEP_FHI   = 2;
    localparam int STEP_CFG   = 3;
    localparam int STEP_PHASE = 4;
    localparam int STEP_UPD   = 5;
endpackage

// File: rtl/dds_phase_calc.sv
// Combinational phase-word correction for the three phase modes.
// Assumes timestamps of at most 64 bits; products are taken modulo 2^64
// and the phase is the slice starting at bit FREQ_W-PHASE_W.
module dds_phase_calc
    import dds_seq_pkg::*;
#(
    parameter int TS_W        = 64,
    parameter int FREQ_W      = 32,
    parameter int PHASE_W     = 16,
    parameter int CLK_RATIO   = 4,
    parameter int SLOT_CYCLES = 5
) (
    input  logic [FREQ_W-1:0]  ftw,
    input  logic [PHASE_W-1:0] pow_in,
    input  phase_mode_e        mode,
    input  logic [TS_W-1:0]    t_ref,
    input  logic [TS_W-1:0]    t_now,
    input  logic [PHASE_W-1:0] comp,
    output logic [PHASE_W-1:0] pow_out
);
    localparam int PROD_W = 64;
    localparam int SHIFT  = FREQ_W - PHASE_W;

    logic [PROD_W-1:0] fud_t, diff, back, fwd;

    // Products for the update-to-reference and zero-to-reference phase.
    always_comb begin
        fud_t = PROD_W'(t_now) + PROD_W'(2 * SLOT_CYCLES);
        diff  = PROD_W'(t_ref) - fud_t;
        back  = diff * PROD_W'(CLK_RATIO) * PROD_W'(ftw);
        fwd   = PROD_W'(t_ref) * PROD_W'(CLK_RATIO) * PROD_W'(ftw);
    end

    // Mode selection of the final phase word.
    always_comb begin
        case (mode)
            MODE_CONT:  pow_out = pow_in + comp;
            MODE_TRACK: pow_out = pow_in - back[SHIFT +: PHASE_W] + fwd[SHIFT +: PHASE_W];
            default:    pow_out = pow_in - back[SHIFT +: PHASE_W];
        endcase
    end
endmodule

// File: rtl/dds_phase_store.sv
// Per-channel store of the phase correction used by continuous mode.
// Assumes the writer only presents in-range channel indices.
module dds_phase_store #(
    parameter int NUM_CH  = 8,
    parameter int IDX_W   = 3,
    parameter int PHASE_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PHASE_W-1:0] wr_val,
    input  logic [IDX_W-1:0]   rd_idx,
    output logic [PHASE_W-1:0] rd_val
);
    logic [PHASE_W-1:0] entry [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_entry
        // Hold one channel's correction; cleared by reset.
        always_ff @(posedge clk) begin
            if (!rst_n)
                entry[g] <= '0;
            else if (wr_en && (32'(wr_idx) == g))
                entry[g] <= wr_val;
        end
    end

    // Read port for the channel being programmed.
    always_comb rd_val = (32'(rd_idx) < NUM_CH) ? entry[rd_idx] : '0;

    // R10
    store_idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (32'(wr_idx) < NUM_CH));
endmodule

// File: rtl/dds_slot_seq.sv
// Step and slot counter: NUM_STEPS writes, each SLOT_CYCLES cycles long,
// with a strobe on the first cycle of every slot. Assumes SLOT_CYCLES >= 2.
module dds_slot_seq
    import dds_seq_pkg::*;
#(
    parameter int SLOT_CYCLES = 5,
    parameter int STEP_W      = $clog2(NUM_STEPS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              busy,
    output logic [STEP_W-1:0] step,
    output logic              slot_stb
);
    localparam int CNT_W = $clog2(SLOT_CYCLES);

    logic [CNT_W-1:0] cnt;

    // Advance the cycle counter inside a slot and the step across slots.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            step <= '0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            step <= '0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CNT_W'(SLOT_CYCLES - 1)) begin
                cnt <= '0;
                if (step == STEP_W'(NUM_STEPS - 1))
                    busy <= 1'b0;
                else
                    step <= step + 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Strobe on the first cycle of each slot.
    always_comb slot_stb = busy && (cnt == '0);

    // R2
    stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_stb |=> !slot_stb);
    // R2
    start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);
endmodule

// File: rtl/dds_phase_sequencer.sv
// Top of the phase-mode programming sequencer. Takes one command through
// a valid/ready handshake and emits the six register writes for it:
// channel select, frequency low/high, accumulator-clear config, phase,
// update strobe. Assumes NUM_CH fits in CH_IN_W bits.
module dds_phase_sequencer
    import dds_seq_pkg::*;
#(
    parameter int NUM_CH      = 8,
    parameter int CH_IN_W     = 8,
    parameter int TS_W        = 64,
    parameter int CLK_RATIO   = 4,
    parameter int SLOT_CYCLES = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [CH_IN_W-1:0] cmd_chan,
    input  logic [31:0]        cmd_ftw,
    input  logic [15:0]        cmd_pow,
    input  logic [1:0]         cmd_mode,
    input  logic [TS_W-1:0]    cmd_ref,
    input  logic [TS_W-1:0]    cmd_now,
    output logic [7:0]         wr_addr,
    output logic [15:0]        wr_data,
    output logic               wr_stb
);
    localparam int IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int STEP_W = $clog2(NUM_STEPS);

    logic               busy, accepted, chan_ok, go, store_en;
    logic [STEP_W-1:0]  step;
    logic [IDX_W-1:0]   ch_q;
    logic [31:0]        ftw_q;
    logic [15:0]        pow_q, comp_rd, pow_calc;
    phase_mode_e        mode_q;
    logic [TS_W-1:0]    ref_q, now_q;

    // Handshake and channel range check.
    always_comb begin
        cmd_ready = !busy;
        accepted  = cmd_valid && cmd_ready;
        chan_ok   = 32'(cmd_chan) < NUM_CH;
        go        = accepted && chan_ok;
    end

    // Capture the command when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            ftw_q  <= '0;
            pow_q  <= '0;
            mode_q <= MODE_CONT;
            ref_q  <= '0;
            now_q  <= '0;
        end else if (go) begin
            ch_q   <= cmd_chan[IDX_W-1:0];
            ftw_q  <= cmd_ftw;
            pow_q  <= cmd_pow;
            mode_q <= phase_mode_e'(cmd_mode);
            ref_q  <= cmd_ref;
            now_q  <= cmd_now;
        end
    end

    dds_slot_seq #(.SLOT_CYCLES(SLOT_CYCLES), .STEP_W(STEP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(go),
        .busy(busy), .step(step), .slot_stb(wr_stb)
    );

    dds_phase_calc #(.TS_W(TS_W), .FREQ_W(32), .PHASE_W(16),
                     .CLK_RATIO(CLK_RATIO), .SLOT_CYCLES(SLOT_CYCLES)) u_calc (
        .ftw(ftw_q), .pow_in(pow_q), .mode(mode_q), .t_ref(ref_q),
        .t_now(now_q), .comp(comp_rd), .pow_out(pow_calc)
    );

    // Store the correction at the phase write of a clearing mode.
    always_comb store_en = wr_stb && (step == STEP_W'(STEP_PHASE)) && (mode_q != MODE_CONT);

    dds_phase_store #(.NUM_CH(NUM_CH), .IDX_W(IDX_W), .PHASE_W(16)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(store_en), .wr_idx(ch_q),
        .wr_val(pow_calc), .rd_idx(ch_q), .rd_val(comp_rd)
    );

    // Address and data of the current write slot.
    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        if (busy) begin
            case (int'(step))
                STEP_SEL:   begin wr_addr = ADDR_SEL;     wr_data = 16'({ch_q, 1'b0}); end
                STEP_FLO:   begin wr_addr = ADDR_FREQ_LO; wr_data = ftw_q[15:0]; end
                STEP_FHI:   begin wr_addr = ADDR_FREQ_HI; wr_data = ftw_q[31:16]; end
                STEP_CFG:   begin wr_addr = ADDR_CFG;
                                  wr_data = (mode_q == MODE_CONT) ? CFG_KEEP : CFG_CLEAR; end
                STEP_PHASE: begin wr_addr = ADDR_PHASE;   wr_data = pow_calc; end
                default:    begin wr_addr = ADDR_UPDATE;  wr_data = '0; end
            endcase
        end
    end

    // R3
    first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> wr_stb && (wr_addr == ADDR_SEL)
               && (wr_data == 16'({$past(cmd_chan[IDX_W-1:0]), 1'b0})));
    // R10
    reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (accepted && !chan_ok) |=> cmd_ready && !wr_stb);
    // R9
    ready_after_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> ($past(wr_addr) == ADDR_UPDATE));
    // R2
    ready_low_on_stb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !cmd_ready);
endmodule

// File: tb/tb_dds_phase_sequencer.sv
module tb_dds_phase_sequencer;
    localparam int NUM_CH = 8;
    localparam int RATIO  = 4;
    localparam int SLOT   = 5;

    typedef struct packed {
        logic [7:0]  ch;
        logic [1:0]  mode;
        logic [31:0] ftw;
        logic [15:0] pw;
        logic [63:0] t_ref;
        logic [63:0] t_now;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{8'd2, 2'd1, 32'h1234_5678, 16'h0100, 64'd1000, 64'd400},
        '{8'd2, 2'd0, 32'h0001_0000, 16'h0010, 64'd0, 64'd0},
        '{8'd5, 2'd2, 32'h8000_0001, 16'hFFF0, 64'd123456789, 64'd123456000},
        '{8'd5, 2'd0, 32'hDEAD_BEEF, 16'h0001, 64'd5, 64'd7},
        '{8'd1, 2'd3, 32'h0000_1000, 16'h4000, 64'd50, 64'd900},
        '{8'd1, 2'd0, 32'h0000_0000, 16'h0002, 64'd3, 64'd3},
        '{8'd0, 2'd0, 32'hFFFF_FFFF, 16'h7777, 64'd9, 64'd1},
        '{8'd7, 2'd2, 32'hCAFE_0000, 16'h0000, 64'hFFFF_FFFF_0000_0000, 64'd16}
    };

    logic clk = 0, rst_n = 0;
    logic cmd_valid = 0, cmd_ready;
    logic [7:0] cmd_chan = 0;
    logic [31:0] cmd_ftw = 0;
    logic [15:0] cmd_pow = 0;
    logic [1:0] cmd_mode = 0;
    logic [63:0] cmd_ref = 0, cmd_now = 0;
    logic [7:0] wr_addr;
    logic [15:0] wr_data;
    logic wr_stb;

    int total = 0, bad = 0;
    logic [15:0] model_comp [NUM_CH];

    always #2 clk = ~clk;

    dds_phase_sequencer #(.NUM_CH(NUM_CH), .CH_IN_W(8), .TS_W(64),
                          .CLK_RATIO(RATIO), .SLOT_CYCLES(SLOT)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_chan(cmd_chan), .cmd_ftw(cmd_ftw), .cmd_pow(cmd_pow),
        .cmd_mode(cmd_mode), .cmd_ref(cmd_ref), .cmd_now(cmd_now),
        .wr_addr(wr_addr), .wr_data(wr_data), .wr_stb(wr_stb)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected phase word from R6, R7, R8.
    function automatic logic [15:0] exp_phase(input logic [1:0] mode, input logic [31:0] ftw,
            input logic [15:0] pw, input logic [63:0] t_ref, input logic [63:0] t_now,
            input logic [15:0] comp);
        logic [63:0] d, back, fwd;
        d    = t_ref - (t_now + 64'(2 * SLOT));
        back = d * 64'(RATIO) * {32'b0, ftw};
        fwd  = t_ref * 64'(RATIO) * {32'b0, ftw};
        if (mode == 2'd0) return pw + comp;
        if (mode == 2'd2) return pw - back[31:16] + fwd[31:16];
        return pw - back[31:16];
    endfunction

    task automatic run_cmd(input vec_t v);
        logic [7:0]  ea [6];
        logic [15:0] ed [6];
        logic [15:0] ph;
        bit valid_ch;
        valid_ch = int'(v.ch) < NUM_CH;
        @(negedge clk);
        check(cmd_ready === 1'b1, "R2 ready before command", 64'(cmd_ready), 1);
        cmd_valid = 1; cmd_chan = v.ch; cmd_mode = v.mode; cmd_ftw = v.ftw;
        cmd_pow = v.pw; cmd_ref = v.t_ref; cmd_now = v.t_now;
        @(negedge clk);
        cmd_valid = 0;
        if (!valid_ch) begin
            // R10: no writes, ready stays high for a full command length
            for (int k = 0; k < 6 * SLOT + 1; k++) begin
                if (wr_stb !== 1'b0 || cmd_ready !== 1'b1)
                    check(0, "R10 write or busy after bad channel", {wr_stb, cmd_ready}, 2'b01);
                @(negedge clk);
            end
            check(cmd_ready === 1'b1 && wr_stb === 1'b0, "R10 idle after bad channel",
                  {wr_stb, cmd_ready}, 2'b01);
            return;
        end
        ph = exp_phase(v.mode, v.ftw, v.pw, v.t_ref, v.t_now, model_comp[v.ch[2:0]]);
        if (v.mode != 2'd0) model_comp[v.ch[2:0]] = ph;
        ea[0] = 8'h81; ed[0] = 16'(v.ch) << 1;                    // R3
        ea[1] = 8'h2D; ed[1] = v.ftw[15:0];                      // R4
        ea[2] = 8'h2F; ed[2] = v.ftw[31:16];                     // R4
        ea[3] = 8'h01; ed[3] = (v.mode == 2'd0) ? 16'h0008 : 16'h2008; // R5
        ea[4] = 8'h31; ed[4] = ph;                               // R6 R7 R8
        ea[5] = 8'h80; ed[5] = 16'h0000;                         // R9
        for (int w = 0; w < 6; w++) begin
            check(wr_stb === 1'b1 && wr_addr === ea[w] && wr_data === ed[w],
                  w == 4 ? "R6_R7_R8 phase write" : (w < 3 ? "R3_R4 select/frequency write" :
                  (w == 3 ? "R5 config write" : "R9 update write")),
                  {wr_stb, wr_addr, wr_data}, {1'b1, ea[w], ed[w]});
            check(cmd_ready === 1'b0, "R2 ready low while busy", 64'(cmd_ready), 0);
            @(negedge clk);
            check(wr_stb === 1'b0 && wr_addr === ea[w] && wr_data === ed[w],
                  "R2 strobe one cycle, slot held", {wr_stb, wr_addr, wr_data}, {1'b0, ea[w], ed[w]});
            repeat (SLOT - 1) @(negedge clk);
        end
        check(cmd_ready === 1'b1, "R9 ready after last slot", 64'(cmd_ready), 1);
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R2 watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        vec_t v;
        for (int c = 0; c < NUM_CH; c++) model_comp[c] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(cmd_ready === 1'b1 && wr_stb === 1'b0 && wr_addr === 8'h00,
              "R1 reset outputs", {cmd_ready, wr_stb, wr_addr}, {1'b1, 1'b0, 8'h00});
        rst_n = 1;
        @(negedge clk);
        check(cmd_ready === 1'b1 && wr_stb === 1'b0, "R1 idle after reset",
              {cmd_ready, wr_stb}, 2'b10);
        // R1: stored correction zero, seen through a continuous command on ch3
        run_cmd('{8'd3, 2'd0, 32'h0000_00AA, 16'h1357, 64'd0, 64'd0});
        for (int i = 0; i < NV; i++) run_cmd(VEC[i]);
        // R10: out-of-range channels that alias channel 0 and 7
        run_cmd('{8'd8, 2'd1, 32'h1111_1111, 16'h2222, 64'd77777, 64'd1});
        run_cmd('{8'd255, 2'd2, 32'h9999_0000, 16'h3333, 64'd4242, 64'd5});
        run_cmd('{8'd0, 2'd0, 32'h0000_0001, 16'h0101, 64'd0, 64'd0});
        run_cmd('{8'd7, 2'd0, 32'h0000_0002, 16'h0202, 64'd0, 64'd0});
        // R8: continuous repeats leave corrections untouched
        run_cmd('{8'd2, 2'd0, 32'h0000_0003, 16'h0000, 64'd0, 64'd0});
        // R1: reset clears stored corrections
        @(negedge clk); rst_n = 0;
        repeat (2) @(negedge clk); rst_n = 1;
        for (int c = 0; c < NUM_CH; c++) model_comp[c] = '0;
        v = '{8'd5, 2'd0, 32'h0000_0004, 16'h0404, 64'd0, 64'd0};
        run_cmd(v);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule